// File: doc/BRIEF.md
# Guard Scalar Mask Unit

This block holds the predicate state for block-guarded execution. A mask register holds one bit per upcoming instruction. Bit 0 is the instruction about to execute, and higher bits are later instructions. A 1 lets that instruction run. A 0 turns it into a NOP.

Guard operations clear positions in the mask. Each guard carries a field of covered positions, a condition value and a polarity. A covered position is cleared when the guard's effective condition is false. Up to four guards may arrive in one cycle, and their effects are combined with AND. Each retired instruction shifts the mask down by one position and feeds a 1 in at the top.

From the current mask the unit drives three outputs:
- a squash bit for the current instruction;
- a flag that reports when no instruction is masked;
- the length of the run of masked instructions starting at the current one, together with the fetch address just past that run.

Save and restore ports let the mask survive an interrupt.

Top module: `gsm_unit`

## Requirements
- R1: After reset the mask holds all ones: `clean`=1, `squash`=0, `skip_vld`=0 and `save_mask`=32'hFFFF_FFFF.
- R2: `squash` is 1 exactly when mask bit 0 (the current instruction) is 0.
- R3: A `retire` pulse moves every mask bit one position toward bit 0 and loads a 1 into bit 31.
- R4: A valid guard with polarity 1 (`guard_pol`=1) and condition 0 clears each mask bit j whose field bit j is 1. Field bits that are 0, or a condition of 1, leave the mask unchanged.
- R5: A guard with polarity 0 uses the inverted condition: with condition 1 it clears the covered bits, and with condition 0 it has no effect.
- R6: Up to four lanes act in the same cycle, and their clearing effects combine with AND. A lane whose `guard_vld` bit is 0 has no effect.
- R7: When a retire and a guard occur in the same cycle, the shift is applied first. Guard field bit j then applies to mask bit j of the shifted mask.
- R8: `rest_vld` loads `rest_mask` into the mask on the next edge and overrides any guard or retire in that cycle.
- R9: `save_mask` always shows the current mask. With no retire, guard or restore, the mask holds its value.
- R10: `skip_cnt` is the number of consecutive 0 bits starting at mask bit 0. `redirect_pc` = `pc_in` + 4*`skip_cnt`, computed combinationally.
- R11: `skip_vld` is 1 only when 0 < `skip_cnt` < 32. An all-zero mask gives `skip_cnt`=32 and `skip_vld`=0.
- R12: `clean` is 1 exactly when all 32 mask bits are 1.
- R13: Guards cover only mask bits 0..20. Bits 21..31 change only through retire or restore.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| guard_vld | input | 4 | Per-lane guard valid |
| guard_field | input | 84 | Four 21-bit position fields; lane k occupies bits 21k+20..21k |
| guard_cond | input | 4 | Per-lane condition value |
| guard_pol | input | 4 | Per-lane polarity (1 = act on true condition, 0 = inverted) |
| retire | input | 1 | One instruction completed |
| rest_vld | input | 1 | Load mask from `rest_mask` |
| rest_mask | input | 32 | Mask value to restore |
| pc_in | input | 32 | Address of the current instruction |
| save_mask | output | 32 | Current mask |
| squash | output | 1 | Current instruction becomes a NOP |
| clean | output | 1 | Mask is all ones |
| skip_vld | output | 1 | Fetch redirect is meaningful |
| skip_cnt | output | 6 | Masked run length from bit 0 |
| redirect_pc | output | 32 | Fetch address past the masked run |

## Verification
Three updates can fall in the same cycle: a retire shift, guard updates and a restore.

The retire-plus-guard case is provoked directly. A known pattern is restored, then one cycle drives a retire together with a guard. The result is judged against the order shift-first, then align. A later cycle drives a restore together with both a guard and a retire, and the restored value must win.

Random phases then mix all three updates across all four lanes. The expected mask comes from a behavioural model in the bench, and every output is compared on every cycle.

// File: rtl/gsm_pkg.sv
package gsm_pkg;
  localparam int unsigned GSM_MASK_W  = 32;
  localparam int unsigned GSM_GUARD_W = 21;
  localparam int unsigned GSM_LANES   = 4;
  localparam int unsigned GSM_PC_W    = 32;
  localparam int unsigned GSM_INSTR_SHIFT = 2;  // 4-byte instructions
endpackage

// File: rtl/gsm_lane_term.sv
// One guard lane: per-position keep term (1 = position survives).
module gsm_lane_term #(
  parameter int unsigned MW = 32,
  parameter int unsigned GW = 21
) (
  input  logic          vld,
  input  logic [GW-1:0] field,
  input  logic          cond,
  input  logic          pol,
  output logic [MW-1:0] keep
);
  logic eff;
  assign eff = pol ? cond : ~cond;

  genvar i;
  generate
    for (i = 0; i < MW; i++) begin : g_pos
      if (i < GW) begin : g_cov
        assign keep[i] = ~(vld & field[i] & ~eff);
      end else begin : g_out
        assign keep[i] = 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/gsm_and_tree.sv
// Combines the keep terms of all lanes.
module gsm_and_tree #(
  parameter int unsigned MW = 32,
  parameter int unsigned NL = 4
) (
  input  logic [NL*MW-1:0] terms,
  output logic [MW-1:0]    all_keep
);
  always_comb begin
    all_keep = '1;
    for (int k = 0; k < NL; k++) begin
      all_keep = all_keep & terms[k*MW +: MW];
    end
  end
endmodule

// File: rtl/gsm_zero_run.sv
// Length of the run of zeros starting at bit 0 (MW if all zero).
module gsm_zero_run #(
  parameter int unsigned MW = 32,
  parameter int unsigned CW = $clog2(MW + 1)
) (
  input  logic [MW-1:0] vec,
  output logic [CW-1:0] cnt
);
  always_comb begin
    cnt = CW'(MW);
    for (int i = MW - 1; i >= 0; i--) begin
      if (vec[i]) cnt = CW'(i);
    end
  end
endmodule

// File: rtl/gsm_unit.sv
module gsm_unit
  import gsm_pkg::*;
#(
  parameter int unsigned MASK_W  = GSM_MASK_W,
  parameter int unsigned GUARD_W = GSM_GUARD_W,
  parameter int unsigned LANES   = GSM_LANES,
  parameter int unsigned PC_W    = GSM_PC_W,
  localparam int unsigned CNT_W  = $clog2(MASK_W + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [LANES-1:0]         guard_vld,
  input  logic [LANES*GUARD_W-1:0] guard_field,
  input  logic [LANES-1:0]         guard_cond,
  input  logic [LANES-1:0]         guard_pol,
  input  logic                     retire,
  input  logic                     rest_vld,
  input  logic [MASK_W-1:0]        rest_mask,
  input  logic [PC_W-1:0]          pc_in,
  output logic [MASK_W-1:0]        save_mask,
  output logic                     squash,
  output logic                     clean,
  output logic                     skip_vld,
  output logic [CNT_W-1:0]         skip_cnt,
  output logic [PC_W-1:0]          redirect_pc
);
  logic [MASK_W-1:0]       mask_q, mask_d, shifted, keep_all;
  logic [LANES*MASK_W-1:0] lane_terms;
  logic                    mask_en;

  genvar k;
  generate
    for (k = 0; k < LANES; k++) begin : g_lane
      gsm_lane_term #(.MW(MASK_W), .GW(GUARD_W)) u_term (
        .vld  (guard_vld[k]),
        .field(guard_field[k*GUARD_W +: GUARD_W]),
        .cond (guard_cond[k]),
        .pol  (guard_pol[k]),
        .keep (lane_terms[k*MASK_W +: MASK_W])
      );
    end
  endgenerate

  gsm_and_tree #(.MW(MASK_W), .NL(LANES)) u_tree (
    .terms   (lane_terms),
    .all_keep(keep_all)
  );

  // next state: shift first, then guards on shifted positions; restore wins
  always_comb begin
    shifted = retire ? {1'b1, mask_q[MASK_W-1:1]} : mask_q;
    mask_d  = rest_vld ? rest_mask : (shifted & keep_all);
    mask_en = rest_vld | retire | (|guard_vld);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

  gsm_zero_run #(.MW(MASK_W), .CW(CNT_W)) u_zrun (
    .vec(mask_q),
    .cnt(skip_cnt)
  );

  assign save_mask   = mask_q;
  assign squash      = ~mask_q[0];
  assign clean       = &mask_q;
  assign skip_vld    = (skip_cnt != '0) && (skip_cnt < CNT_W'(MASK_W));
  assign redirect_pc = pc_in + (PC_W'(skip_cnt) << GSM_INSTR_SHIFT);
endmodule

// File: rtl/gsm_unit_chk.sv
module gsm_unit_chk #(
  parameter int unsigned MASK_W  = 32,
  parameter int unsigned GUARD_W = 21,
  parameter int unsigned LANES   = 4,
  parameter int unsigned CNT_W   = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [LANES-1:0]  guard_vld,
  input logic              retire,
  input logic              rest_vld,
  input logic [MASK_W-1:0] rest_mask,
  input logic [MASK_W-1:0] save_mask,
  input logic              squash,
  input logic              clean,
  input logic              skip_vld,
  input logic [CNT_W-1:0]  skip_cnt
);
  p_restore_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rest_vld |=> save_mask == $past(rest_mask));

  p_retire_shift_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && !rest_vld && guard_vld == '0) |=>
      save_mask == {1'b1, $past(save_mask[MASK_W-1:1])});

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!retire && !rest_vld && guard_vld == '0) |=> $stable(save_mask));

  p_squash_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
    squash == (skip_cnt != '0));

  p_skip_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
    skip_vld |-> (skip_cnt != '0 && skip_cnt < CNT_W'(MASK_W)));

  p_clean_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    clean |-> (!squash && !skip_vld));

  generate
    if (MASK_W > GUARD_W) begin : g_hi
      p_upper_untouched_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!retire && !rest_vld) |=>
          save_mask[MASK_W-1:GUARD_W] == $past(save_mask[MASK_W-1:GUARD_W]));
    end
  endgenerate
endmodule

bind gsm_unit gsm_unit_chk #(
  .MASK_W(MASK_W), .GUARD_W(GUARD_W), .LANES(LANES), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .guard_vld(guard_vld), .retire(retire),
  .rest_vld(rest_vld), .rest_mask(rest_mask), .save_mask(save_mask),
  .squash(squash), .clean(clean), .skip_vld(skip_vld), .skip_cnt(skip_cnt)
);

// File: tb/gsm_unit_test.sv
`timescale 1ns/1ps
module gsm_unit_test;
  localparam int MW = 32, GW = 21, NL = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NL-1:0] guard_vld, guard_cond, guard_pol;
  logic [NL*GW-1:0] guard_field;
  logic          retire, rest_vld;
  logic [MW-1:0] rest_mask, save_mask;
  logic [31:0]   pc_in, redirect_pc;
  logic          squash, clean, skip_vld;
  logic [5:0]    skip_cnt;

  int checks = 0, fails = 0;
  logic [MW-1:0] model;
  bit done = 0;

  always #2.5 clk = ~clk;

  gsm_unit uut (.*);

  task automatic idle();
    guard_vld = '0; guard_cond = '0; guard_pol = '0; guard_field = '0;
    retire = 0; rest_vld = 0; rest_mask = '0;
  endtask

  task automatic set_lane(int k, logic [GW-1:0] f, logic c, logic p);
    guard_vld[k] = 1'b1;
    guard_field[k*GW +: GW] = f;
    guard_cond[k] = c;
    guard_pol[k] = p;
  endtask

  task automatic model_update();
    logic [MW-1:0] m;
    m = model;
    if (rest_vld) begin
      m = rest_mask;
    end else begin
      if (retire) begin
        for (int i = 0; i < MW - 1; i++) m[i] = model[i+1];
        m[MW-1] = 1'b1;
      end
      for (int k = 0; k < NL; k++) begin
        logic e;
        e = guard_pol[k] ? guard_cond[k] : !guard_cond[k];
        if (guard_vld[k] && !e)
          for (int j = 0; j < GW; j++)
            if (guard_field[k*GW + j]) m[j] = 1'b0;
      end
    end
    model = m;
  endtask

  task automatic compare(string tag);
    int run;
    bit ok;
    logic [31:0] exp_pc;
    run = 0;
    while (run < MW && model[run] == 1'b0) run++;
    exp_pc = pc_in + 32'(run * 4);
    ok = (save_mask === model) && (squash === !model[0]) &&
         (clean === (model == '1)) && (skip_cnt === 6'(run)) &&
         (skip_vld === (run > 0 && run < MW)) && (redirect_pc === exp_pc);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: mask=%h sq=%b cl=%b sv=%b cnt=%0d pc=%h expected mask=%h cnt=%0d pc=%h",
               tag, save_mask, squash, clean, skip_vld, skip_cnt, redirect_pc,
               model, run, exp_pc);
    end
  endtask

  task automatic step(string tag);
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare(tag);
    idle();
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    idle();
    pc_in = 32'h0000_1000;
    model = '1;
    rst_n = 0;
    repeat (3) @(negedge clk);
    compare("R1 reset during");
    rst_n = 1;
    @(negedge clk);
    compare("R1 after reset");
    step("R12 idle clean");
    retire = 1; step("R3 retire on all ones");
    set_lane(0, 21'h5, 1'b0, 1'b1); step("R4 clear bits 0,2 R2 squash");
    retire = 1; step("R3 shift after guard");
    set_lane(1, 21'h1FFFFF, 1'b1, 1'b1); step("R4 true cond no effect");
    rest_mask = '1; rest_vld = 1; step("R8 restore ones");
    set_lane(2, 21'h3, 1'b1, 1'b0); step("R5 inverted cond clears");
    rest_mask = '1; rest_vld = 1; step("R8 restore");
    set_lane(3, 21'h8, 1'b0, 1'b0); step("R5 inverted cond zero no effect");
    set_lane(0, 21'h10, 1'b0, 1'b1); set_lane(1, 21'h20, 1'b0, 1'b1);
    set_lane(2, 21'h40, 1'b1, 1'b0); set_lane(3, 21'h80, 1'b1, 1'b1);
    step("R6 four lanes");
    guard_field[0 +: GW] = 21'h1; guard_cond[0] = 0; guard_pol[0] = 1;
    step("R6 invalid lane ignored");
    rest_mask = 32'hFFFF_FFFE; rest_vld = 1; step("R8 restore pattern R2 squash");
    retire = 1; set_lane(0, 21'h2, 1'b0, 1'b1); step("R7 retire with guard");
    retire = 1; set_lane(1, 21'h1FFFFF, 1'b0, 1'b1);
    rest_mask = 32'hFFFF_FFF0; rest_vld = 1; step("R8 restore beats both");
    pc_in = 32'h0000_2000; step("R10 redirect count 4");
    rest_mask = '0; rest_vld = 1; step("R11 all zero mask");
    rest_mask = '1; rest_vld = 1; step("R8 restore ones again");
    set_lane(0, 21'h1FFFFF, 1'b0, 1'b1); step("R13 upper bits kept R11 run 21");
    for (int n = 0; n < 21; n++) begin
      retire = 1; step("R3 drain to clean R12");
    end
    rest_mask = 32'h8000_0000; rest_vld = 1; step("R11 run 31 valid");
    for (int n = 0; n < 600; n++) begin
      pc_in = $urandom;
      for (int k = 0; k < NL; k++)
        if ($urandom_range(0, 2) == 0)
          set_lane(k, 21'($urandom), 1'($urandom), 1'($urandom));
      retire = ($urandom_range(0, 1) == 1);
      if ($urandom_range(0, 15) == 0) begin
        rest_vld = 1; rest_mask = $urandom;
      end
      step("R6 R7 random mix");
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule